// File: doc/BRIEF.md
# Retention and Prefetch-Distance Tuning Controller

This controller chooses a retention time for a reduced-retention magnetic L1 cache and a prefetch distance to go with it. A start pulse begins a profiling sweep. The controller applies each of five candidate retention times in turn. While a candidate is applied, external monitor counters run for one measurement window. At the end of each window, a `win_done` pulse presents four counter snapshots: accesses, misses, prefetches issued, and prefetched blocks that expired without being used.

The sweep begins with the longest candidate, 1 ms, which serves as the baseline. It then moves from the shortest candidate to the longest. When the last window closes, the controller makes its choice and applies the selected retention time and its prefetch distance together. It raises `done` for one cycle at that moment.

The selection rule depends on how much prefetching the baseline window shows:
- **Prefetching present:** the controller picks the shortest candidate whose wasted-prefetch fraction is small enough, judged either against the baseline fraction or against an absolute floor.
- **Prefetching negligible:** the controller falls back to a miss-count rule.

All percentage tests are done by cross-multiplying counts, so the block needs no divider.

Retention select encoding: 0 = 25 us, 1 = 50 us, 2 = 75 us, 3 = 100 us, 4 = 1 ms.

Top module: `ret_tune_ctrl`

## Requirements
- R1: After reset, `ret_sel` is 4, `pf_dist` is 16 and `done` is 0.
- R2: A `start` pulse seen while idle sets `ret_sel` to 4 on the following cycle. Each later `win_done` advances `ret_sel` through 0, 1, 2 and 3, one step per pulse. A `start` pulse during a sweep is ignored, and so is a `win_done` pulse while idle.
- R3: If the baseline window satisfies prefetches×1000 < accesses, the prefetch metrics are ignored. The choice is then the shortest candidate whose misses are at most baseline misses + floor(baseline misses / 8).
- R4: Otherwise, a candidate qualifies when expired×baseline_prefetches ≤ 2×baseline_expired×prefetches. This means its wasted fraction is at most twice the baseline fraction. The boundary case counts as qualifying.
- R5: A candidate also qualifies when expired×5000 < prefetches, which means a wasted fraction below 0.02 %. Equality does not qualify. Under R4 and R5, the shortest qualifying candidate is chosen.
- R6: If no candidate qualifies under the active rule, `ret_sel` becomes 4.
- R7: On apply, `pf_dist` is set by the chosen candidate: 0→4, 1→8, 2→12, 3 or 4→16. `pf_dist` does not change during a sweep.
- R8: `done` is high for exactly one cycle, two cycles after the clock edge that takes the final `win_done`. The new `ret_sel` and `pf_dist` are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a profiling sweep |
| win_done | input | 1 | Measurement window ended; snapshots valid |
| acc_cnt | input | CW | Access count of the window |
| miss_cnt | input | CW | Miss count of the window |
| pf_cnt | input | CW | Prefetches issued in the window |
| exp_cnt | input | CW | Prefetched blocks expired unused in the window |
| ret_sel | output | 3 | Applied retention candidate (encoding above) |
| pf_dist | output | DW | Applied prefetch distance |
| done | output | 1 | One-cycle pulse when new settings take effect |

## Verification
The bench builds the block with its default 16-bit counters, a distance step of 4 and the default denominators 1000 and 5000. With 16-bit counters, window counts of up to 65535 are legal. That range is enough to place snapshots exactly on both thresholds: a 0.1 % prefetch rate at equality, a doubled baseline fraction at equality, and 1 expired block in 5000 or 5001 prefetches. It also makes it possible to construct windows where the miss rule and the prefetch rule would pick different candidates, which shows which rule is in force.

// File: rtl/ret_tune_ctrl.sv
module ret_tune_ctrl #(
  parameter int CW        = 16,
  parameter int DW        = 5,
  parameter int DIST_STEP = 4,
  parameter int NEG_DEN   = 1000,
  parameter int ABS_DEN   = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          win_done,
  input  logic [CW-1:0] acc_cnt,
  input  logic [CW-1:0] miss_cnt,
  input  logic [CW-1:0] pf_cnt,
  input  logic [CW-1:0] exp_cnt,
  output logic [2:0]    ret_sel,
  output logic [DW-1:0] pf_dist,
  output logic          done
);
  localparam int PW = 2*CW + 16;
  localparam logic [2:0] LONGEST = 3'd4;
  localparam logic [DW-1:0] MAX_DIST = DW'(4*DIST_STEP);

  typedef enum logic [1:0] {S_IDLE, S_PROF, S_EVAL, S_APPLY} st_t;

  st_t st;
  logic [2:0]    step, pick;
  logic          neg, found;
  logic [CW-1:0] b_pf, b_exp, b_miss;

  wire [2:0]    cand = (step == 3'd0) ? LONGEST : step - 3'd1;
  wire [PW-1:0] pf_w  = PW'(pf_cnt);
  wire [PW-1:0] exp_w = PW'(exp_cnt);

  wire neg_now = pf_w * PW'(NEG_DEN) < PW'(acc_cnt);
  wire rel_ok  = exp_w * PW'(b_pf) <= ((PW'(b_exp) * pf_w) << 1);
  wire abs_ok  = exp_w * PW'(ABS_DEN) < pf_w;
  wire miss_ok = {1'b0, miss_cnt} <= ({1'b0, b_miss} + {4'b0, b_miss[CW-1:3]});
  wire ok      = neg ? miss_ok : (rel_ok || abs_ok);

  wire [2:0] final_sel = found ? pick : LONGEST;

  function automatic logic [DW-1:0] dist_of(input logic [2:0] s);
    if (s >= 3'd3) return MAX_DIST;
    return DW'((int'(s) + 1) * DIST_STEP);
  endfunction

  assign done = (st == S_APPLY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      step    <= 3'd0;
      pick    <= LONGEST;
      neg     <= 1'b0;
      found   <= 1'b0;
      b_pf    <= '0;
      b_exp   <= '0;
      b_miss  <= '0;
      ret_sel <= LONGEST;
      pf_dist <= MAX_DIST;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st      <= S_PROF;
          step    <= 3'd0;
          found   <= 1'b0;
          ret_sel <= LONGEST;
        end
        S_PROF: if (win_done) begin
          if (step == 3'd0) begin
            b_pf   <= pf_cnt;
            b_exp  <= exp_cnt;
            b_miss <= miss_cnt;
            neg    <= neg_now;
          end else if (ok && !found) begin
            found <= 1'b1;
            pick  <= cand;
          end
          if (step == 3'd4) st <= S_EVAL;
          else begin
            step    <= step + 3'd1;
            ret_sel <= step;
          end
        end
        S_EVAL: begin
          ret_sel <= final_sel;
          pf_dist <= dist_of(final_sel);
          st      <= S_APPLY;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (ret_sel == LONGEST && !done));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> ($stable(ret_sel) && $stable(pf_dist)));

  assert_dist_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((ret_sel >= 3'd3) == (pf_dist == MAX_DIST)));

  assert_sweep_dist_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROF) |=> $stable(pf_dist));

  assert_sel_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_sel <= LONGEST);
endmodule

// File: tb/tb_ret_tune_ctrl.sv
module tb_ret_tune_ctrl;
  localparam int CW = 16;
  localparam int DW = 5;
  localparam int NV = 8;

  // rows: {acc,miss,pf,exp} for 1ms, 25us, 50us, 75us, 100us windows, then expected select
  localparam int TV [NV][21] = '{
    '{10000,500,1000,10, 10000,500,1000,50, 10000,500,1000,15, 10000,500,1000,15, 10000,500,1000,15, 1}, // R4
    '{10000,500,1000,10, 10000,500,1000,20, 10000,500,1000,50, 10000,500,1000,50, 10000,500,1000,50, 0}, // R4 boundary
    '{10000,500,1000,10, 10000,500,1000,30, 10000,500,1000,30, 10000,500,1000,30, 10000,500,1000,30, 4}, // R6
    '{20000,500,10000,0, 20000,500,10000,1, 20000,500,10000,1, 20000,500,10000,1, 20000,500,10000,1, 0}, // R5
    '{20000,500,5000,0,  20000,500,5000,1,  20000,500,5000,1,  20000,500,5001,1,  20000,500,5001,1,  2}, // R5 boundary
    '{10000,800,9,0,     10000,1000,9,0,    10000,901,9,0,     10000,900,9,0,     10000,100,9,0,     2}, // R3
    '{10000,100,10,1,    10000,100,10,5,    10000,100,10,5,    10000,100,10,5,    10000,100,10,2,    3}, // R3 edge, R4
    '{10000,800,0,0,     10000,2000,0,0,    10000,2000,0,0,    10000,2000,0,0,    10000,2000,0,0,    4}  // R3 and R6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic win_done = 1'b0;
  logic [CW-1:0] acc_cnt = '0, miss_cnt = '0, pf_cnt = '0, exp_cnt = '0;
  logic [2:0] ret_sel;
  logic [DW-1:0] pf_dist;
  logic done;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ret_tune_ctrl #(.CW(CW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .win_done(win_done),
    .acc_cnt(acc_cnt), .miss_cnt(miss_cnt), .pf_cnt(pf_cnt), .exp_cnt(exp_cnt),
    .ret_sel(ret_sel), .pf_dist(pf_dist), .done(done));

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int dist_for(input int s);
    return (s >= 3) ? 16 : (s + 1) * 4;
  endfunction

  task automatic run_vec(input int vi, input bit glitch);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(int'(ret_sel), 4, "R2 sweep begins at 1ms");
    for (int i = 0; i < 5; i++) begin
      acc_cnt  = CW'(TV[vi][4*i]);
      miss_cnt = CW'(TV[vi][4*i+1]);
      pf_cnt   = CW'(TV[vi][4*i+2]);
      exp_cnt  = CW'(TV[vi][4*i+3]);
      win_done = 1'b1;
      if (glitch && i == 2) start = 1'b1;
      @(negedge clk);
      win_done = 1'b0;
      start = 1'b0;
      if (i < 4) begin
        chk(int'(ret_sel), i, "R2 sweep order");
        chk(int'(pf_dist), glitch ? 16 : int'(pf_dist), "R7 distance held in sweep");
      end else chk(int'(done), 0, "R8 done latency");
    end
    @(negedge clk);
    chk(int'(done), 1, "R8 done raised");
    chk(int'(ret_sel), TV[vi][20], "R3/R4/R5/R6 selection");
    chk(int'(pf_dist), dist_for(TV[vi][20]), "R7 distance map");
    @(negedge clk);
    chk(int'(done), 0, "R8 done single cycle");
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(ret_sel), 4, "R1 reset select");
    chk(int'(pf_dist), 16, "R1 reset distance");
    chk(int'(done), 0, "R1 reset done");
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) run_vec(v, 1'b0);

    // R2: start during sweep ignored
    run_vec(1, 1'b1);

    // R2: win_done while idle ignored
    acc_cnt = 16'd10000; miss_cnt = 16'd0; pf_cnt = 16'd1000; exp_cnt = 16'd0;
    @(negedge clk) win_done = 1'b1;
    @(negedge clk) win_done = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(int'(ret_sel), 0, "R2 idle window ignored select");
      chk(int'(pf_dist), 4, "R2 idle window ignored distance");
      chk(int'(done), 0, "R2 idle window no done");
      @(negedge clk);
    end

    // R1: reset mid-sweep restores defaults
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    win_done = 1'b1;
    @(negedge clk) win_done = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(int'(ret_sel), 4, "R1 reset mid-sweep select");
    chk(int'(pf_dist), 16, "R1 reset mid-sweep distance");
    chk(int'(done), 0, "R1 reset mid-sweep done");
    rst_n = 1'b1;
    run_vec(0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule